// File: doc/BRIEF.md
# UART Modem Handshake and Loopback Unit

This unit is the modem-handshake slice of a byte-wide, register-mapped UART. It holds the control register that drives the four outgoing handshake lines. It also builds the status byte from the four incoming handshake lines. That byte carries the current line levels plus sticky change flags. A change on a line raises an interrupt request, provided the enable input allows it. The unit also chooses which serial line feeds the receiver shifter.

Setting control bit 4 puts the unit in diagnostic loopback. The transmitter's serial bit goes straight back to the receiver, and the TX pin rests at mark (high). The four outgoing pins go to their inactive level. The status inputs are taken from the control bits and no longer from the pins. A driver can therefore exercise the shifters, the change flags and the interrupt path without any external wiring. The baud timing, the shifters, the FIFOs and the interrupt priority logic are in neighbouring blocks.

Top module: `modem_loop_unit`

## Requirements
- R1: After reset, the control register reads 0x00 and the status register reads 0x00. The pins dtr_n, rts_n, out1_n and out2_n are high, and irq_modem is low.
- R2: A write to the control address (reg_addr=0) stores reg_wdata[4:0]. A read returns those bits with bits [7:5] as zero. Outside loopback, dtr_n, rts_n, out1_n and out2_n are the inverse of control bits 0, 1, 2 and 3.
- R3: Outside loopback, status bits 4, 5, 6 and 7 (status address, reg_addr=1) show the inverted pins cts_n, dsr_n, ri_n and dcd_n. A pin change driven before a clock edge is not visible after two rising edges. It is visible after the third.
- R4: Status bits 0, 1 and 3 set whenever the effective CTS, DSR or DCD level changes. Status bit 2 sets only when the effective RI goes from active to inactive. The flags are sticky.
- R5: A read strobe (reg_rd with reg_addr=1) clears status bits [3:0] at the following edge, unless a new change is detected in that same cycle.
- R6: irq_modem is high exactly when msi_en is high and at least one of status bits [3:0] is set.
- R7: With control bit 4 set, status bits 4, 5, 6 and 7 follow control bits 0 (DTR), 1 (RTS), 2 (OUT1) and 3 (OUT2). They update one clock after the write. The change flags of R4 are derived from these looped values.
- R8: In loopback, changes on cts_n, dsr_n, dcd_n and ri_n leave the status register unchanged.
- R9: In loopback, tx_pin is high and rx_bit_o equals tx_bit_i, with rx_pin ignored. Otherwise, tx_pin equals tx_bit_i and rx_bit_o equals rx_pin.
- R10: In loopback, dtr_n, rts_n, out1_n and out2_n are held high whatever the control bits are.
- R11: Entering or leaving loopback sets a change flag only for a status input whose effective value differs across the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe (control address only) |
| reg_rd | input | 1 | Read strobe; clears change flags when reg_addr=1 |
| reg_wdata | input | 5 | Control bits to store |
| reg_rdata | output | 8 | Read data of the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| irq_modem | output | 1 | Modem-status interrupt request |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| tx_pin | output | 1 | Serial output pin |
| rx_pin | input | 1 | Serial input pin |
| tx_bit_i | input | 1 | Serial bit from the transmit shifter |
| rx_bit_o | output | 1 | Serial bit to the receive shifter |

## Verification
The change detector is driven with a single CTS edge, two lines moving together, and RI going both ways. These cases separate the any-edge flags from the trailing-edge RI flag, and show that the flags combine correctly. Loopback is driven with several control patterns, each activating a different line. A crossed mapping, for example DTR landing on DSR, therefore shows up as a wrong status bit. The pins are toggled while in loopback to show that they are isolated. Entry is made with control bits equal to the live line levels, and exit is made with a difference on two lines. Together these cases separate correct change detection from flags raised just because the source switched. The serial taps are driven with opposite levels on tx_bit_i and rx_pin, so a wrong route is visible.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned DATA_W    = 2 * NUM_LINES;
  localparam int unsigned CTL_W     = NUM_LINES + 1;
  localparam int unsigned LOOP_BIT  = NUM_LINES;
  localparam int unsigned SYNC_STG  = 2;

  // Active-high status inputs; bit order matches status register [3:0]/[7:4]
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;
endpackage

// File: rtl/modem_sync_bank.sv
module modem_sync_bank #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTL_W-1:0]     wdata,
  output logic [CTL_W-1:0]     ctl_q,
  output logic [NUM_LINES-1:0] pins_n
);
  logic [CTL_W-1:0] ctl_d;
  logic             loop_on;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign loop_on = ctl_q[LOOP_BIT];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pin
    assign pins_n[g] = loop_on ? 1'b1 : ~ctl_q[g];
  end
endmodule

// File: rtl/modem_loop_router.sv
module modem_loop_router
  import modem_pkg::*;
(
  input  logic                 loop_on,
  input  logic [NUM_LINES-1:0] ctl_lines,
  input  mline_t               ext_act,
  input  logic                 tx_bit_i,
  input  logic                 rx_pin,
  output mline_t               eff,
  output logic                 tx_pin,
  output logic                 rx_bit_o
);
  mline_t looped;

  always_comb begin
    looped.cts = ctl_lines[0];
    looped.dsr = ctl_lines[1];
    looped.ri  = ctl_lines[2];
    looped.dcd = ctl_lines[3];
    eff        = loop_on ? looped : ext_act;
    tx_pin     = loop_on ? 1'b1 : tx_bit_i;
    rx_bit_o   = loop_on ? tx_bit_i : rx_pin;
  end
endmodule

// File: rtl/modem_delta_unit.sv
module modem_delta_unit
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mline_t            eff,
  input  logic              rd_clr,
  input  logic              msi_en,
  output logic [DATA_W-1:0] status_o,
  output logic              irq
);
  mline_t               eff_q;
  logic [NUM_LINES-1:0] dlt_q, dlt_d, set_v;
  mline_t               chg;

  always_comb begin
    chg      = eff ^ eff_q;
    set_v[0] = chg.cts;
    set_v[1] = chg.dsr;
    set_v[2] = eff_q.ri & ~eff.ri;
    set_v[3] = chg.dcd;
    dlt_d    = (rd_clr ? '0 : dlt_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
      dlt_q <= '0;
    end else begin
      eff_q <= eff;
      dlt_q <= dlt_d;
    end
  end

  assign status_o = {eff_q, dlt_q};
  assign irq      = msi_en & (|dlt_q);

  a_r4_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt_q[2]) |-> ($past(eff_q.ri) && !eff_q.ri));
  a_r4_cts_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt_q[0]) |-> (eff_q.cts != $past(eff_q.cts)));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (eff == eff_q)) |=> (dlt_q == '0));
  a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_o[NUM_LINES-1:0] != '0));
endmodule

// File: rtl/modem_loop_unit.sv
module modem_loop_unit
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              msi_en,
  output logic              irq_modem,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              dcd_n,
  input  logic              ri_n,
  output logic              tx_pin,
  input  logic              rx_pin,
  input  logic              tx_bit_i,
  output logic              rx_bit_o
);
  logic [1:0]           rst_pipe;
  logic                 rst_s;
  logic [CTL_W-1:0]     ctl_q;
  logic [NUM_LINES-1:0] pins_n;
  logic [NUM_LINES-1:0] ext_raw_n, ext_sync_n;
  mline_t               ext_act, eff;
  logic [DATA_W-1:0]    status;
  logic                 loop_on;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  modem_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_s),
    .wr_en (reg_wr & ~reg_addr),
    .wdata (reg_wdata),
    .ctl_q (ctl_q),
    .pins_n(pins_n)
  );
  assign loop_on = ctl_q[LOOP_BIT];
  assign dtr_n   = pins_n[0];
  assign rts_n   = pins_n[1];
  assign out1_n  = pins_n[2];
  assign out2_n  = pins_n[3];

  assign ext_raw_n = {dcd_n, ri_n, dsr_n, cts_n};
  modem_sync_bank #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_s),
    .din  (ext_raw_n),
    .dout (ext_sync_n)
  );
  assign ext_act = mline_t'(~ext_sync_n);

  modem_loop_router u_route (
    .loop_on  (loop_on),
    .ctl_lines(ctl_q[NUM_LINES-1:0]),
    .ext_act  (ext_act),
    .tx_bit_i (tx_bit_i),
    .rx_pin   (rx_pin),
    .eff      (eff),
    .tx_pin   (tx_pin),
    .rx_bit_o (rx_bit_o)
  );

  modem_delta_unit u_delta (
    .clk     (clk),
    .rst_n   (rst_s),
    .eff     (eff),
    .rd_clr  (reg_rd & reg_addr),
    .msi_en  (msi_en),
    .status_o(status),
    .irq     (irq_modem)
  );

  assign reg_rdata = reg_addr ? status : {{(DATA_W-CTL_W){1'b0}}, ctl_q};

  a_r7_loop_map: assert property (@(posedge clk) disable iff (!rst_s)
    $past(loop_on) |-> (status[7:4] == $past(ctl_q[3:0])));
  a_r9_tx_mark: assert property (@(posedge clk) disable iff (!rst_s)
    loop_on |-> (tx_pin && (rx_bit_o == tx_bit_i)));
  a_r10_pins_idle: assert property (@(posedge clk) disable iff (!rst_s)
    loop_on |-> (dtr_n && rts_n && out1_n && out2_n));
endmodule

// File: tb/sim_modem_loop_unit.sv
module sim_modem_loop_unit;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_addr, reg_wr, reg_rd, msi_en;
  logic [4:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic irq_modem, dtr_n, rts_n, out1_n, out2_n;
  logic cts_n, dsr_n, dcd_n, ri_n;
  logic tx_pin, rx_pin, tx_bit_i, rx_bit_o;

  always #(CLK_PER/2) clk = ~clk;

  modem_loop_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_en(msi_en), .irq_modem(irq_modem),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
    .tx_pin(tx_pin), .rx_pin(rx_pin), .tx_bit_i(tx_bit_i), .rx_bit_o(rx_bit_o)
  );

  typedef struct {
    string       req;
    logic [14:0] exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [4:0] ctl_m;   // bench model of the control register

  wire [14:0] obs = {irq_modem, tx_pin, rx_bit_o, dtr_n, rts_n, out1_n, out2_n, reg_rdata};

  // expected observation from the requirements
  function automatic logic [14:0] model(input logic irq, input logic [7:0] data);
    logic lp;
    logic [3:0] p;
    lp = ctl_m[4];
    p  = lp ? 4'b1111 : ~ctl_m[3:0];
    return {irq, lp ? 1'b1 : tx_bit_i, lp ? tx_bit_i : rx_pin,
            p[0], p[1], p[2], p[3], data};
  endfunction

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      sb_item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      n_vec++;
      if (obs !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, obs, it.exp);
      end
    end
  end

  task automatic peek(input string req, input logic sel, input logic irq, input logic [7:0] data);
    sb_item_t it;
    @(negedge clk);
    reg_addr = sel;
    #1;
    it.req = req;
    it.exp = model(irq, data);
    sb_q.push_back(it);
    #1;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = v[4:0];
    @(negedge clk);
    reg_wr = 1'b0;
    ctl_m = v[4:0];
  endtask

  task automatic rd_stat();
    @(negedge clk);
    reg_addr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_pins(input logic c, input logic d, input logic cd, input logic r);
    @(negedge clk);
    cts_n = c; dsr_n = d; dcd_n = cd; ri_n = r;
  endtask

  task automatic set_ser(input logic t, input logic r);
    @(negedge clk);
    tx_bit_i = t; rx_pin = r;
  endtask

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    msi_en = 1'b1; cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1; ri_n = 1'b1;
    rx_pin = 1'b1; tx_bit_i = 1'b1; ctl_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek("R1 control", 1'b0, 1'b0, 8'h00);
    peek("R1 status",  1'b1, 1'b0, 8'h00);

    // R2 control writes and pin drive
    wr_ctl(8'h0F);
    peek("R2 all lines on", 1'b0, 1'b0, 8'h0F);
    wr_ctl(8'hE5);
    peek("R2 upper bits zero", 1'b0, 1'b0, 8'h05);

    // R9 normal serial routing
    set_ser(1'b0, 1'b1);
    peek("R9 normal tx0 rx1", 1'b0, 1'b0, 8'h05);
    set_ser(1'b1, 1'b0);
    peek("R9 normal tx1 rx0", 1'b0, 1'b0, 8'h05);

    // R3 latency and R4/R6 CTS edge
    set_pins(1'b0, 1'b1, 1'b1, 1'b1);
    peek("R3 not yet after 1", 1'b1, 1'b0, 8'h00);
    peek("R3 not yet after 2", 1'b1, 1'b0, 8'h00);
    peek("R3 R4 R6 cts seen", 1'b1, 1'b1, 8'h11);
    @(negedge clk); msi_en = 1'b0;
    peek("R6 masked", 1'b1, 1'b0, 8'h11);
    @(negedge clk); msi_en = 1'b1;

    // R5 read clears
    rd_stat();
    peek("R5 cleared", 1'b1, 1'b0, 8'h10);

    // R4 RI leading edge sets no flag, trailing edge does
    set_pins(1'b0, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    peek("R4 ri active no flag", 1'b1, 1'b0, 8'h50);
    set_pins(1'b0, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    peek("R4 ri trailing flag", 1'b1, 1'b1, 8'h14);
    rd_stat();

    // R4 two lines at once
    set_pins(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    peek("R4 dsr and dcd", 1'b1, 1'b1, 8'hBA);
    rd_stat();
    peek("R5 cleared again", 1'b1, 1'b0, 8'hB0);

    // R11 enter loopback matching live levels: cts,dsr,dcd on, ri off
    wr_ctl(8'h1B);
    peek("R11 quiet entry", 1'b1, 1'b0, 8'hB0);
    peek("R10 R2 loop readback", 1'b0, 1'b0, 8'h1B);
    set_ser(1'b0, 1'b1);
    peek("R9 loop tx0", 1'b0, 1'b0, 8'h1B);
    set_ser(1'b1, 1'b0);
    peek("R9 loop tx1 rx ignored", 1'b0, 1'b0, 8'h1B);

    // R7 mapping patterns
    wr_ctl(8'h14);
    peek("R7 out1 to ri", 1'b1, 1'b1, 8'h4B);
    rd_stat();
    wr_ctl(8'h10);
    peek("R7 R4 looped ri trailing", 1'b1, 1'b1, 8'h04);
    rd_stat();
    wr_ctl(8'h11);
    peek("R7 dtr to cts", 1'b1, 1'b1, 8'h11);
    rd_stat();
    wr_ctl(8'h12);
    peek("R7 rts to dsr", 1'b1, 1'b1, 8'h23);
    rd_stat();
    wr_ctl(8'h18);
    peek("R7 out2 to dcd", 1'b1, 1'b1, 8'h8A);
    rd_stat();
    peek("R5 loop clear", 1'b1, 1'b0, 8'h80);

    // R8 pins isolated in loopback
    set_pins(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    peek("R8 pins ignored", 1'b1, 1'b0, 8'h80);

    // R11 leave loopback with two differing lines (ri on, dcd off)
    wr_ctl(8'h00);
    peek("R11 exit flags", 1'b1, 1'b1, 8'h48);
    peek("R10 R9 exit pins", 1'b0, 1'b1, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule